// File: doc/BRIEF.md
# Software Interrupt Acceptance Filter

This block sits beside the pending state of the sixteen software-generated interrupt IDs of one processor. Each clock it may receive one request. A request names an ID, the group it asks for (0 or 1) and whether it came from the non-secure world. The block decides whether to take the request. A taken request sets the pending bit of its ID. A refused request is dropped with no side effect. The accept or drop verdict appears on the same cycle as the request.

The decision has three parts. First, a group-1 request aimed at an ID that is configured as group 0 is lowered to group 0. Second, the request's group must equal the group configured for the ID. Third, when the request is non-secure and security is not globally disabled, a 2-bit per-ID permission field must reach a threshold: at least 1 for group 0 and at least 2 for group 1. Software can clear pending bits with a clear mask. If a set and a clear hit the same ID in the same cycle, the set wins.

Top module: `sgi_accept_filter`

## Requirements
- R1: After reset, `pending` reads all zeros.
- R2: A group-1 request (`reqGrp`=1) to an ID whose `cfgGroup` bit is 0 is handled as a group-0 request, so it can be accepted.
- R3: A group-0 request (`reqGrp`=0) to an ID whose `cfgGroup` bit is 1 is dropped, whatever the permission field and security state.
- R4: When `reqNonSec`=0 or `secDisable`=1, the permission field has no effect on the decision.
- R5: The permission field of ID n is `permWord[2n+1:2n]`, read as an unsigned value. A non-secure group-0 request with `secDisable`=0 is accepted only if this field is at least 1.
- R6: A non-secure group-1 request with `secDisable`=0 is accepted only if the field of its ID is at least 2.
- R7: With `reqValid`=1, exactly one of `accept` and `drop` is high in the same cycle. With `reqValid`=0, both are low. On accept, `setPulse` has only the bit of the ID set, and that `pending` bit is 1 after the next rising edge.
- R8: A request with `reqId` of 16 or more is dropped and sets no bit.
- R9: Bits set in `clrMask` clear the matching `pending` bits at the next edge. If an accepted request targets a bit that is being cleared in the same cycle, that bit ends up set.
- R10: A dropped request, or no request, leaves every `pending` bit unchanged apart from clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present this cycle |
| reqId | input | 5 | Requested interrupt ID |
| reqGrp | input | 1 | Requested group (0 or 1) |
| reqNonSec | input | 1 | Request originates from the non-secure world |
| secDisable | input | 1 | Global security-disable flag |
| cfgGroup | input | 16 | Configured group, one bit per ID |
| permWord | input | 32 | 2-bit permission field per ID, ID n at bits 2n+1:2n |
| clrMask | input | 16 | Clear-pending strobe per ID |
| accept | output | 1 | Request accepted this cycle |
| drop | output | 1 | Request dropped this cycle |
| setPulse | output | 16 | One-hot pending-set pulse for the accepted ID |
| pending | output | 16 | Pending state per ID |

## Verification
The bench uses the default build: 16 IDs, 2-bit permission fields and a 5-bit ID port. This lets it sweep every ID from 0 to 17 against every combination of requested group, configured group, non-secure flag, security-disable flag and all four permission values. So the out-of-range IDs 16 and 17 are covered together with every threshold edge. In each step, the bench gives the other IDs the opposite group and the opposite permission value. A wrong field index or group bit index then changes the verdict. Separate steps preload pending bits and apply clear masks to show that a set wins over a clear and that a drop changes nothing.

// File: rtl/sgi_filter_pkg.sv
package sgi_filter_pkg;
  localparam int SGI_NUM = 16;

  typedef struct packed {
    logic                accept;
    logic                drop;
    logic [SGI_NUM-1:0]  setOneHot;
  } sgiStrobe_t;
endpackage

// File: rtl/sgi_filter_ctrl.sv
module sgi_filter_ctrl
  import sgi_filter_pkg::*;
#(
  parameter int NUM_IDS  = SGI_NUM,
  parameter int ID_W     = 5,
  parameter int PERM_W   = 2,
  parameter int GRP0_MIN = 1,
  parameter int GRP1_MIN = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic [ID_W-1:0]           reqId,
  input  logic                      reqGrp,
  input  logic                      reqNonSec,
  input  logic                      secDisable,
  input  logic [NUM_IDS-1:0]        cfgGroup,
  input  logic [NUM_IDS*PERM_W-1:0] permWord,
  output sgiStrobe_t                strobe
);
  localparam int IDX_W = $clog2(NUM_IDS);

  logic              idInRange;
  logic [IDX_W-1:0]  idx;
  logic              cfgGrp;
  logic              effGrp;
  logic              grpMatch;
  logic [PERM_W-1:0] permField;
  logic              permNeeded;
  logic              permOk;
  logic              take;

  assign idInRange  = (reqId < ID_W'(NUM_IDS));
  assign idx        = reqId[IDX_W-1:0];
  assign cfgGrp     = cfgGroup[idx];
  // A group-1 ask on a group-0 ID is lowered to group 0
  assign effGrp     = reqGrp & cfgGrp;
  assign grpMatch   = (effGrp == cfgGrp);
  assign permField  = permWord[idx*PERM_W +: PERM_W];
  assign permNeeded = reqNonSec & ~secDisable;
  assign permOk     = cfgGrp ? (int'(permField) >= GRP1_MIN)
                             : (int'(permField) >= GRP0_MIN);
  assign take       = reqValid & idInRange & grpMatch & (~permNeeded | permOk);

  assign strobe.accept = take;
  assign strobe.drop   = reqValid & ~take;

  for (genvar i = 0; i < NUM_IDS; i++) begin : g_dec
    assign strobe.setOneHot[i] = take & (idx == IDX_W'(i));
  end

  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (strobe.accept ^ strobe.drop)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!strobe.accept && !strobe.drop)); // R7
  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.setOneHot) && (strobe.accept == (strobe.setOneHot != '0))); // R7
  AST_HIGH_ID_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqId >= ID_W'(NUM_IDS)) |-> !strobe.accept); // R8
  AST_GRP0_ON_GRP1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqGrp && cfgGroup[idx]) |-> !strobe.accept); // R3
  AST_NS_GRP1_PERM: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accept && reqNonSec && !secDisable && reqGrp && cfgGroup[idx])
      |-> (int'(permWord[idx*PERM_W +: PERM_W]) >= GRP1_MIN)); // R6
endmodule

// File: rtl/sgi_filter_dp.sv
module sgi_filter_dp
  import sgi_filter_pkg::*;
#(
  parameter int NUM_IDS = SGI_NUM
) (
  input  logic               clk,
  input  logic               rstN,
  input  sgiStrobe_t         strobe,
  input  logic [NUM_IDS-1:0] clrMask,
  output logic [NUM_IDS-1:0] setPulse,
  output logic [NUM_IDS-1:0] pending
);
  assign setPulse = strobe.setOneHot;

  for (genvar i = 0; i < NUM_IDS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rstN)                     pending[i] <= 1'b0;
      else if (strobe.setOneHot[i])  pending[i] <= 1'b1;
      else if (clrMask[i])           pending[i] <= 1'b0;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (setPulse != '0) |=> ((pending & $past(setPulse)) == $past(setPulse))); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    (setPulse == '0) |=> ((pending & ~$past(pending)) == '0)); // R10
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (clrMask != '0) |=> ((pending & $past(clrMask) & ~$past(setPulse)) == '0)); // R9
endmodule

// File: rtl/sgi_accept_filter.sv
module sgi_accept_filter
  import sgi_filter_pkg::*;
#(
  parameter int NUM_IDS  = SGI_NUM,
  parameter int ID_W     = 5,
  parameter int PERM_W   = 2,
  parameter int GRP0_MIN = 1,
  parameter int GRP1_MIN = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic [ID_W-1:0]           reqId,
  input  logic                      reqGrp,
  input  logic                      reqNonSec,
  input  logic                      secDisable,
  input  logic [NUM_IDS-1:0]        cfgGroup,
  input  logic [NUM_IDS*PERM_W-1:0] permWord,
  input  logic [NUM_IDS-1:0]        clrMask,
  output logic                      accept,
  output logic                      drop,
  output logic [NUM_IDS-1:0]        setPulse,
  output logic [NUM_IDS-1:0]        pending
);
  sgiStrobe_t strobe;

  sgi_filter_ctrl #(
    .NUM_IDS(NUM_IDS), .ID_W(ID_W), .PERM_W(PERM_W),
    .GRP0_MIN(GRP0_MIN), .GRP1_MIN(GRP1_MIN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqId(reqId),
    .reqGrp(reqGrp), .reqNonSec(reqNonSec), .secDisable(secDisable),
    .cfgGroup(cfgGroup), .permWord(permWord), .strobe(strobe)
  );

  sgi_filter_dp #(.NUM_IDS(NUM_IDS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .clrMask(clrMask),
    .setPulse(setPulse), .pending(pending)
  );

  assign accept = strobe.accept;
  assign drop   = strobe.drop;
endmodule

// File: tb/sgi_accept_filter_tb.sv
module sgi_accept_filter_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic        reqValid = 0;
  logic [4:0]  reqId = '0;
  logic        reqGrp = 0, reqNonSec = 0, secDisable = 0;
  logic [15:0] cfgGroup = '0;
  logic [31:0] permWord = '0;
  logic [15:0] clrMask = '0;
  logic        accept, drop;
  logic [15:0] setPulse, pending;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sgi_accept_filter u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqId(reqId),
    .reqGrp(reqGrp), .reqNonSec(reqNonSec), .secDisable(secDisable),
    .cfgGroup(cfgGroup), .permWord(permWord), .clrMask(clrMask),
    .accept(accept), .drop(drop), .setPulse(setPulse), .pending(pending)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearAll();
    @(negedge clk);
    reqValid = 0; clrMask = '1;
    @(negedge clk);
    clrMask = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pending at reset", pending, 0);
    rstN = 1;
    @(negedge clk);
    chk("R1 pending after reset", pending, 0);
    chk("R7 idle accept/drop", {accept, drop}, 0);

    // Sweep
    for (int id = 0; id < 18; id++)
      for (int rg = 0; rg < 2; rg++)
        for (int cg = 0; cg < 2; cg++)
          for (int ns = 0; ns < 2; ns++)
            for (int sd = 0; sd < 2; sd++)
              for (int f = 0; f < 4; f++) begin
                bit ok;
                bit permApplies;
                int effG;
                string tag;
                logic [15:0] expOh;
                clearAll();
                for (int j = 0; j < 16; j++) begin
                  cfgGroup[j] = (j == id) ? cg[0] : ~cg[0];
                  permWord[2*j +: 2] = (j == id) ? f[1:0] : ~f[1:0];
                end
                reqValid = 1; reqId = id[4:0]; reqGrp = rg[0];
                reqNonSec = ns[0]; secDisable = sd[0];
                effG = (rg == 1 && cg == 0) ? 0 : rg;
                permApplies = (ns == 1) && (sd == 0);
                ok = (id < 16) && (effG == cg) &&
                     (!permApplies || (cg == 1 ? f >= 2 : f >= 1));
                if (id >= 16) tag = "R8";
                else if (effG != cg) tag = "R3";
                else if (permApplies) tag = (cg == 1) ? "R6" : "R5";
                else if (rg == 1 && cg == 0) tag = "R2";
                else tag = "R4";
                expOh = ok ? (16'h1 << id) : 16'h0;
                #1;
                chk($sformatf("%s verdict id=%0d rg=%0d cg=%0d ns=%0d sd=%0d f=%0d", tag, id, rg, cg, ns, sd, f),
                    {accept, drop}, ok ? 2'b10 : 2'b01);
                chk($sformatf("%s setPulse id=%0d", tag, id), setPulse, expOh);
                @(posedge clk); #1;
                chk($sformatf("%s pending id=%0d (R7/R10)", tag, id), pending, expOh);
                reqValid = 0;
              end

    // R9: set wins over simultaneous clear; clears apply elsewhere
    clearAll();
    secDisable = 1; cfgGroup = '0; reqGrp = 0;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      reqValid = 1; reqId = 5'(j * 3);
    end
    @(negedge clk);
    reqValid = 0;
    chk("R7 pending after four sets", pending, 16'h0249);
    reqValid = 1; reqId = 5'd3; clrMask = 16'hFFFF;
    @(posedge clk); #1;
    chk("R9 set wins over clear", pending, 16'h0008);
    @(negedge clk);
    reqValid = 0; clrMask = 16'h0000;
    reqValid = 1; reqId = 5'd7;
    @(negedge clk);
    reqValid = 0; clrMask = 16'h0008;
    @(posedge clk); #1;
    chk("R9 clear removes only masked bit", pending, 16'h0080);
    @(negedge clk);
    clrMask = '0;
    // R10: dropped request leaves state
    reqValid = 1; reqId = 5'd20;
    #1;
    chk("R8 high id drop", {accept, drop}, 2'b01);
    @(posedge clk); #1;
    chk("R10 pending unchanged after drop", pending, 16'h0080);
    @(negedge clk);
    reqValid = 0;
    @(posedge clk); #1;
    chk("R10 pending unchanged when idle", pending, 16'h0080);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule